// File: doc/BRIEF.md
# Split-Line Instruction Fetch Aligner

This block sits between an instruction cache and the instruction decoders. The cache is organised in 32-byte lines, and each line is seen as two 16-byte halves. On every fetch the aligner asks for two neighbouring half lines: the half that holds the fetch pointer and the half after it. When the pointer lies in the upper half of a line, that second half is the lower half of the next line. The block joins the two halves into a 32-byte window. It then rotates the window so that the byte at the fetch pointer lands in byte 0. Each result is stored, together with its count of useful bytes, in one of four line-sized prefetch buffers.

Instruction bytes may begin at any byte address. The count of useful bytes is 32 minus the pointer's offset inside its half, so even the worst alignment yields 17 bytes. After each fetch the pointer advances by that count. A consumer reads the oldest buffer and releases it with a consume pulse. A redirect empties every buffer and loads a new pointer, and fetching from that pointer begins in the following cycle.

A small state machine controls the sequence. `FA_IDLE` is the state after reset; no pointer is known and nothing is fetched. `FA_FILL` fetches one window per cycle. `FA_FULL` holds the fetch while all four buffers are occupied. The transitions are as follows. A redirect goes from any state to `FA_FILL`. A fetch that fills the last free buffer, with no consume in the same cycle, goes from `FA_FILL` to `FA_FULL`. A consume goes from `FA_FULL` back to `FA_FILL`.

Top module: `fetch_window_aligner`

## Requirements
- R1: After reset, and until the first redirect, `win_valid_o` is 0, `win_count_o` is 0 and `win_bytes_o` is all zeros.
- R2: While a pointer P is loaded, `lo_half_addr_o` equals P >> 4 and `hi_half_addr_o` equals (P >> 4) + 1. When P[4] is 1, the second half therefore belongs to the next 32-byte line.
- R3: In a buffered window, byte j (bits 8j+7 down to 8j) holds the byte at address P + j for every j below the count. Every byte at or above the count is zero.
- R4: The count stored with a window fetched at pointer P is 32 − P[3:0]. It is always between 17 and 32.
- R5: Each fetch advances the pointer by its own count, so consecutive windows cover consecutive bytes with no gap and no overlap.
- R6: At most four windows are held. With four buffered and no consume, no fetch happens, and the half-line addresses hold the pointer of the next unfetched window.
- R7: Windows leave in fetch order. A consume pulse while `win_valid_o` is 1 releases the oldest window, and the next oldest appears on the outputs after that clock edge.
- R8: A redirect sampled at a clock edge empties all buffers at that edge (`win_valid_o` is 0 after it) and loads the redirect address as the pointer. The first window from that address is presented after the following edge.
- R9: A consume pulse while no window is buffered has no effect: no window is lost and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| redirect_i | input | 1 | Flush buffers and load a new fetch pointer |
| redirect_addr_i | input | ADDR_W (32) | New fetch pointer, any byte address |
| consume_i | input | 1 | Release the oldest buffered window |
| lo_half_addr_o | output | ADDR_W-4 (28) | Half-line index holding the fetch pointer |
| hi_half_addr_o | output | ADDR_W-4 (28) | Index of the following half line |
| lo_half_data_i | input | 128 | Bytes of the half line at `lo_half_addr_o`, byte 0 in bits 7:0 |
| hi_half_data_i | input | 128 | Bytes of the half line at `hi_half_addr_o`, byte 0 in bits 7:0 |
| win_valid_o | output | 1 | A buffered window is presented |
| win_count_o | output | 6 | Useful bytes in the presented window (0 when none) |
| win_bytes_o | output | 256 | Presented window, pointer byte in bits 7:0 |

## Verification
Some properties are checked by assertions on every cycle:

- every stored count lies between 17 and 32;
- no fetch writes into a full bank;
- a fetch moves the pointer by exactly its count;
- a consume on an empty bank leaves the occupancy at zero;
- a redirect always leaves the outputs empty after the next edge.

The byte contents of each window, the crossing into the next line, and the ordering of windows can only be shown by the bench's scenarios, checked against an address-derived memory model. The same applies to the absence of gaps between successive windows and to the pointer held during a full-bank stall.

// File: rtl/fa_pkg.sv
package fa_pkg;
    typedef enum logic [1:0] {
        FA_IDLE = 2'd0,
        FA_FILL = 2'd1,
        FA_FULL = 2'd2
    } fa_state_e;
endpackage

// File: rtl/fa_rotator.sv
module fa_rotator #(
    parameter int HALF_B = 16,
    localparam int LINE_B = 2 * HALF_B,
    localparam int OFF_W  = $clog2(HALF_B),
    localparam int CNT_W  = $clog2(LINE_B + 1)
) (
    input  logic [HALF_B*8-1:0] lo_i,
    input  logic [HALF_B*8-1:0] hi_i,
    input  logic [OFF_W-1:0]    off_i,
    output logic [LINE_B*8-1:0] rot_o,
    output logic [CNT_W-1:0]    cnt_o
);
    logic [LINE_B*8-1:0] window;
    logic [OFF_W+2:0]    shamt;

    assign window = {hi_i, lo_i};
    assign shamt  = {off_i, 3'b000};

    // Right shift by whole bytes fills the tail with zero bytes.
    assign rot_o = window >> shamt;
    assign cnt_o = CNT_W'(LINE_B) - CNT_W'(off_i);
endmodule

// File: rtl/fa_buffer_bank.sv
module fa_buffer_bank #(
    parameter int LINE_B = 32,
    parameter int DEPTH  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OCC_W = $clog2(DEPTH + 1),
    localparam int CNT_W = $clog2(LINE_B + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush_i,
    input  logic                push_i,
    input  logic [LINE_B*8-1:0] push_data_i,
    input  logic [CNT_W-1:0]    push_cnt_i,
    input  logic                pop_i,
    output logic [OCC_W-1:0]    occ_o,
    output logic                head_valid_o,
    output logic [LINE_B*8-1:0] head_data_o,
    output logic [CNT_W-1:0]    head_cnt_o
);
    logic [LINE_B*8-1:0] data_q [DEPTH];
    logic [CNT_W-1:0]    cnt_q  [DEPTH];
    logic [IDX_W-1:0]    wr_q, rd_q;
    logic [OCC_W-1:0]    occ_q;
    logic                pop_ok;

    assign head_valid_o = (occ_q != '0);
    assign pop_ok       = pop_i && head_valid_o;
    assign occ_o        = occ_q;
    assign head_data_o  = head_valid_o ? data_q[rd_q] : '0;
    assign head_cnt_o   = head_valid_o ? cnt_q[rd_q]  : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            occ_q <= '0;
        end else if (flush_i) begin
            wr_q  <= '0;
            rd_q  <= '0;
            occ_q <= '0;
        end else begin
            if (push_i) begin
                wr_q <= (int'(wr_q) == DEPTH - 1) ? '0 : wr_q + 1'b1;
            end
            if (pop_ok) begin
                rd_q <= (int'(rd_q) == DEPTH - 1) ? '0 : rd_q + 1'b1;
            end
            occ_q <= occ_q + OCC_W'(push_i) - OCC_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_i && !flush_i) begin
            data_q[wr_q] <= push_data_i;
            cnt_q[wr_q]  <= push_cnt_i;
        end
    end

    // R6: the controller never writes into a full bank
    a_r6_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (int'(occ_q) < DEPTH));

    // R9: a release request on an empty bank leaves it empty
    a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && occ_q == '0 && !push_i && !flush_i) |=> (occ_q == '0));
endmodule

// File: rtl/fa_fetch_ctrl.sv
module fa_fetch_ctrl
    import fa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_B = 32,
    parameter int DEPTH  = 4,
    localparam int HALF_B = LINE_B / 2,
    localparam int OCC_W  = $clog2(DEPTH + 1),
    localparam int CNT_W  = $clog2(LINE_B + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect_i,
    input  logic [ADDR_W-1:0] redirect_addr_i,
    input  logic              pop_i,
    input  logic [OCC_W-1:0]  occ_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              push_o
);
    fa_state_e         state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic              last_slot;

    assign last_slot = (int'(occ_i) == DEPTH - 1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FA_IDLE: if (redirect_i) state_d = FA_FILL;
            FA_FILL: begin
                if (redirect_i)                     state_d = FA_FILL;
                else if (!pop_i && last_slot)       state_d = FA_FULL;
            end
            FA_FULL: begin
                if (redirect_i || pop_i)            state_d = FA_FILL;
            end
            default: state_d = FA_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FA_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        push_o = (state_q == FA_FILL) && !redirect_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ptr_q <= '0;
        else if (redirect_i) ptr_q <= redirect_addr_i;
        else if (push_o)     ptr_q <= ptr_q + ADDR_W'(cnt_i);
    end

    assign ptr_o = ptr_q;

    // R4: every stored count lies in the useful range
    a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> (int'(cnt_i) >= HALF_B + 1 && int'(cnt_i) <= LINE_B));

    // R5: each fetch steps the pointer by the count it stored
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> (ptr_q == $past(ptr_q) + ADDR_W'($past(cnt_i))));
endmodule

// File: rtl/fetch_window_aligner.sv
module fetch_window_aligner #(
    parameter int ADDR_W = 32,
    parameter int HALF_B = 16,
    parameter int DEPTH  = 4,
    localparam int LINE_B = 2 * HALF_B,
    localparam int OFF_W  = $clog2(HALF_B),
    localparam int HIDX_W = ADDR_W - OFF_W,
    localparam int CNT_W  = $clog2(LINE_B + 1),
    localparam int OCC_W  = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                redirect_i,
    input  logic [ADDR_W-1:0]   redirect_addr_i,
    input  logic                consume_i,
    output logic [HIDX_W-1:0]   lo_half_addr_o,
    output logic [HIDX_W-1:0]   hi_half_addr_o,
    input  logic [HALF_B*8-1:0] lo_half_data_i,
    input  logic [HALF_B*8-1:0] hi_half_data_i,
    output logic                win_valid_o,
    output logic [CNT_W-1:0]    win_count_o,
    output logic [LINE_B*8-1:0] win_bytes_o
);
    logic [ADDR_W-1:0]   ptr;
    logic                push;
    logic [OCC_W-1:0]    occ;
    logic [LINE_B*8-1:0] rot;
    logic [CNT_W-1:0]    cnt;
    logic                pop;

    assign pop            = consume_i && win_valid_o;
    assign lo_half_addr_o = ptr[ADDR_W-1:OFF_W];
    assign hi_half_addr_o = ptr[ADDR_W-1:OFF_W] + 1'b1;

    fa_rotator #(.HALF_B(HALF_B)) u_rot (
        .lo_i  (lo_half_data_i),
        .hi_i  (hi_half_data_i),
        .off_i (ptr[OFF_W-1:0]),
        .rot_o (rot),
        .cnt_o (cnt)
    );

    fa_fetch_ctrl #(.ADDR_W(ADDR_W), .LINE_B(LINE_B), .DEPTH(DEPTH)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .redirect_i      (redirect_i),
        .redirect_addr_i (redirect_addr_i),
        .pop_i           (pop),
        .occ_i           (occ),
        .cnt_i           (cnt),
        .ptr_o           (ptr),
        .push_o          (push)
    );

    fa_buffer_bank #(.LINE_B(LINE_B), .DEPTH(DEPTH)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (redirect_i),
        .push_i       (push),
        .push_data_i  (rot),
        .push_cnt_i   (cnt),
        .pop_i        (consume_i),
        .occ_o        (occ),
        .head_valid_o (win_valid_o),
        .head_data_o  (win_bytes_o),
        .head_cnt_o   (win_count_o)
    );

    // R8: a redirect leaves no stale window on the outputs
    a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> !win_valid_o);
endmodule

// File: tb/fetch_window_aligner_test.sv
`timescale 1ns/1ps
module fetch_window_aligner_test;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         redirect_i = 0;
    logic [31:0]  redirect_addr_i = '0;
    logic         consume_i = 0;
    logic [27:0]  lo_half_addr_o, hi_half_addr_o;
    logic [127:0] lo_half_data_i, hi_half_data_i;
    logic         win_valid_o;
    logic [5:0]   win_count_o;
    logic [255:0] win_bytes_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [31:0] exp_ptr;
    bit          first_win;

    always #2 clk = ~clk;

    fetch_window_aligner uut (.*);

    function automatic logic [7:0] memb(logic [31:0] a);
        return a[7:0] ^ {a[14:8], 1'b0} ^ a[31:24] ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [127:0] half_of(logic [27:0] h);
        logic [127:0] r;
        for (int b = 0; b < 16; b++) r[b*8 +: 8] = memb({h, 4'(b)});
        return r;
    endfunction

    function automatic logic [255:0] exp_window(logic [31:0] p);
        logic [255:0] r;
        int c;
        c = 32 - int'(p[3:0]);
        r = '0;
        for (int j = 0; j < 32; j++) if (j < c) r[j*8 +: 8] = memb(p + 32'(j));
        return r;
    endfunction

    assign lo_half_data_i = half_of(lo_half_addr_o);
    assign hi_half_data_i = half_of(hi_half_addr_o);

    task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic do_redirect(logic [31:0] a, bit eat);
        redirect_i = 1; redirect_addr_i = a;
        @(posedge clk); #1;
        redirect_i = 0;
        chk(win_valid_o == 0, "R8 flush", 256'(win_valid_o), 0);
        chk(lo_half_addr_o == a[31:4], "R2 lo half", 256'(lo_half_addr_o), 256'(a[31:4]));
        chk(hi_half_addr_o == a[31:4] + 28'd1, "R2 hi half", 256'(hi_half_addr_o), 256'(a[31:4] + 28'd1));
        exp_ptr = a; first_win = 1;
        if (eat) begin
            consume_i = 1;
            @(posedge clk); #1;
            consume_i = 0;
            chk(win_valid_o && win_count_o == 6'(32 - int'(a[3:0])), "R9 empty consume",
                256'(win_count_o), 256'(32 - int'(a[3:0])));
        end
    endtask

    task automatic pop_check();
        int c;
        for (int k = 0; k < 20 && !win_valid_o; k++) begin @(posedge clk); #1; end
        c = 32 - int'(exp_ptr[3:0]);
        chk(win_valid_o, "R7 window present", 256'(win_valid_o), 1);
        chk(win_count_o == 6'(c), "R4 count", 256'(win_count_o), 256'(c));
        chk(win_bytes_o == exp_window(exp_ptr), first_win ? "R3 bytes" : "R5 contiguous bytes",
            win_bytes_o, exp_window(exp_ptr));
        first_win = 0;
        consume_i = 1;
        @(posedge clk); #1;
        consume_i = 0;
        exp_ptr = exp_ptr + 32'(c);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] p, held;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        // R1: reset state and idle without redirect
        chk(!win_valid_o && win_count_o == 0 && win_bytes_o == 0, "R1 reset", win_bytes_o, 0);
        repeat (5) @(posedge clk); #1;
        chk(!win_valid_o && win_count_o == 0, "R1 idle", 256'(win_count_o), 0);

        do_redirect(32'h0000_1000, 0); pop_check(); pop_check();  // aligned, count 32
        do_redirect(32'h0000_010F, 0); pop_check(); pop_check();  // worst case 17
        do_redirect(32'h0000_011F, 0); pop_check();              // R2 crossing to next line
        do_redirect(32'h0000_0233, 1); pop_check(); pop_check();  // R9

        // R6: fill four windows, fetch halts at the next pointer
        do_redirect(32'h0000_0203, 0);
        repeat (8) @(posedge clk); #1;
        p = 32'h0000_0203;
        for (int k = 0; k < 4; k++) p = p + 32'(32 - int'(p[3:0]));
        held = {lo_half_addr_o, 4'h0};
        chk(lo_half_addr_o == p[31:4], "R6 stalled pointer", 256'(lo_half_addr_o), 256'(p[31:4]));
        repeat (3) @(posedge clk); #1;
        chk({lo_half_addr_o, 4'h0} == held, "R6 stall stable", 256'(lo_half_addr_o), 256'(held[31:4]));
        for (int k = 0; k < 6; k++) pop_check();  // R7 order

        // R8: redirect while full
        repeat (8) @(posedge clk); #1;
        do_redirect(32'h00AB_CDE9, 0); pop_check(); pop_check();

        for (int it = 0; it < 60; it++) begin
            p = $urandom();
            do_redirect(p, ($urandom() % 4) == 0);
            for (int k = 0; k < 1 + int'($urandom() % 6); k++) begin
                repeat ($urandom() % 3) @(posedge clk);
                #0;
                pop_check();
            end
        end
        done = 1;
        finish_run();
    end
endmodule